// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

This block is a parallel I/O port of `W` pins in which every pin is also wired to one on-chip peripheral. Software reaches the port through a small register bus with three live addresses: a direction register, an output latch and a pin-state view. The block drives tri-state pad controls (`pad_out`, `pad_oe`) and samples the pad inputs through a two-flop synchroniser.

A pin goes to the peripheral only when two things are true: the peripheral is enabled and it raises its output enable for that pin. Otherwise the port's direction and latch decide what the pad does.

The peripheral input path is gated. A level that the port itself drives onto a pin never reaches the peripheral's input for that pin. A `MASK` parameter marks which pins exist. Bits for pins that do not exist read as zero in every register, never drive the pad, and ignore writes.

The register bus and the pin signals are plain control and status wires with no valid/ready handshake. A write is a single-cycle strobe, and there is no back-pressure. Read data is combinational from the address.

Top module: `shared_gpio_port`

## Requirements
- R1: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A direction bit of 0 enables the pad driver with `pad_out` equal to the latch bit.
- R2: On a synchronous active-high reset, every implemented direction bit becomes 1 and the latch becomes 0, so no pad is driven.
- R3: Address 1 reads back the latch, and a write to address 1 loads the latch on the next rising edge.
- R4: Address 2 reads the pad levels after two clock edges of synchronisation. A write to address 2 loads the latch exactly as a write to address 1 does.
- R5: While `periph_en` is 1 and `periph_oe[i]` is 1, `pad_oe[i]` is 1 and `pad_out[i]` equals `periph_do[i]`, whatever the direction and latch bits hold.
- R6: When `periph_en` is 0, or `periph_oe[i]` is 0, the port's direction and latch control pin i.
- R7: Address 2 still returns the synchronised pad level of a pin while the peripheral owns that pin.
- R8: `periph_di[i]` is 0 while the port drives pin i. In every other case it is the synchronised pad level.
- R9: For bits outside `MASK`, all reads return 0, `pad_oe` and `pad_out` stay 0, and writes have no effect.
- R10: Address 0 is the direction register. Address 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 direction, 1 latch, 2 pin view, 3 unused) |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for `reg_addr` |
| periph_en | input | 1 | Peripheral enabled |
| periph_oe | input | W | Peripheral per-pin output enable |
| periph_do | input | W | Peripheral output data |
| periph_di | output | W | Gated, synchronised pin levels to the peripheral |
| pad_in | input | W | Raw pad input levels |
| pad_out | output | W | Pad output data |
| pad_oe | output | W | Pad output enable |

## Verification
The output multiplexer is tried with several direction and ownership patterns:
- All pins as inputs while the peripheral is disabled with its enables raised, which separates gating by enable from gating by per-pin enable.
- All pins as outputs, which exposes a swapped latch or peripheral data path.
- A mixed split in which the peripheral owns some input and some output pins, which shows that ownership overrides direction.
- An owner pattern that touches the unimplemented bit, which proves masking on the pad.

Pin reads are checked one edge and two edges after a pad change, which tells a correct synchroniser depth from a short one. Loop-through gating is checked with the port driving, with the pin as an input, and with the peripheral owning the pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    GP_DIR  = 2'd0,
    GP_LAT  = 2'd1,
    GP_PIN  = 2'd2,
    GP_NONE = 2'd3
  } gp_addr_e;
endpackage

// File: rtl/gp_regfile.sv
module gp_regfile
  import gpio_port_pkg::*;
#(
  parameter int          W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wen,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q
);
  logic dir_hit, lat_hit;

  assign dir_hit = wen && (gp_addr_e'(addr) == GP_DIR);
  // writes to the pin view land in the latch
  assign lat_hit = wen && ((gp_addr_e'(addr) == GP_LAT) || (gp_addr_e'(addr) == GP_PIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= MASK;
      lat_q <= '0;
    end else begin
      if (dir_hit) dir_q <= wdata & MASK;
      if (lat_hit) lat_q <= wdata & MASK;
    end
  end
endmodule

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gp_pin_mux.sv
module gp_pin_mux #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         periph_en,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] periph_oe,
  input  logic [W-1:0] periph_do,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] periph_di
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (MASK[i]) begin : g_live
      logic owned, port_drv;
      assign owned        = periph_en & periph_oe[i];
      assign port_drv     = ~owned & ~dir_q[i];
      assign pad_oe[i]    = owned | port_drv;
      assign pad_out[i]   = owned ? periph_do[i] : lat_q[i];
      assign periph_di[i] = pin_sync[i] & ~port_drv;
    end else begin : g_dead
      assign pad_oe[i]    = 1'b0;
      assign pad_out[i]   = 1'b0;
      assign periph_di[i] = 1'b0;
    end
  end
endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int           W          = 16,
  parameter logic [W-1:0] MASK       = 16'hBFFF,
  parameter int           SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wen,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         periph_en,
  input  logic [W-1:0] periph_oe,
  input  logic [W-1:0] periph_do,
  output logic [W-1:0] periph_di,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] dir_q, lat_q, pin_sync;

  gp_regfile #(.W(W), .MASK(MASK)) u_regs (
    .clk(clk), .rst(rst), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .lat_q(lat_q)
  );

  gp_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gp_pin_mux #(.W(W), .MASK(MASK)) u_mux (
    .periph_en(periph_en), .dir_q(dir_q), .lat_q(lat_q),
    .periph_oe(periph_oe), .periph_do(periph_do), .pin_sync(pin_sync),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_di(periph_di)
  );

  always_comb begin
    unique case (gp_addr_e'(reg_addr))
      GP_DIR:  reg_rdata = dir_q;
      GP_LAT:  reg_rdata = lat_q;
      GP_PIN:  reg_rdata = pin_sync & MASK;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gp_port_checker.sv
module gp_port_checker #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wen,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic         periph_en,
  input logic [W-1:0] periph_oe,
  input logic [W-1:0] periph_di,
  input logic [W-1:0] pad_oe
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !periph_en) |-> (pad_oe == '0)); // R2

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && (reg_addr == 2'd1 || reg_addr == 2'd2))
      |=> (reg_addr != 2'd1 || reg_rdata == ($past(reg_wdata) & MASK))); // R4

  AST_OWNER_DRIVES: assert property (@(posedge clk) disable iff (rst)
    ((periph_en ? periph_oe : '0) & MASK & ~pad_oe) == '0); // R5

  AST_NO_LOOPBACK: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~(periph_en ? periph_oe : '0) & periph_di) == '0); // R8

  AST_DEAD_BITS: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata | pad_oe | periph_di) & ~MASK) == '0); // R9

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd3) |-> (reg_rdata == '0)); // R10
endmodule

bind shared_gpio_port gp_port_checker #(.W(W), .MASK(MASK)) u_chk (
  .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_en(periph_en),
  .periph_oe(periph_oe), .periph_di(periph_di), .pad_oe(pad_oe)
);

// File: tb/test_shared_gpio_port.sv
`timescale 1ns/1ps
module test_shared_gpio_port;
  localparam int          W    = 16;
  localparam logic [15:0] MASK = 16'hBFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wen = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0, periph_oe = '0, periph_do = '0, pad_in = '0;
  logic periph_en = 1'b0;
  logic [W-1:0] reg_rdata, periph_di, pad_out, pad_oe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  shared_gpio_port #(.W(W), .MASK(MASK)) i_shared_gpio_port (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_en(periph_en),
    .periph_oe(periph_oe), .periph_do(periph_do), .periph_di(periph_di),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // vector: dir, latch, en(bit0), oe, do, expected oe, expected out
  localparam logic [111:0] VEC [5] = '{
    {16'hFFFF, 16'h1234, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h1234},
    {16'h0000, 16'hA5C3, 16'h0000, 16'hFFFF, 16'h0000, 16'hBFFF, 16'hA5C3},
    {16'h00FF, 16'hF0F0, 16'h0001, 16'h0F0F, 16'h3333, 16'hBF0F, 16'hB3F3},
    {16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 16'hFFFF, 16'h0000, 16'hBFFF},
    {16'hFFFF, 16'h0000, 16'h0001, 16'hC001, 16'h4001, 16'h8001, 16'h0001}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    rd(2'd0, r); check("R2 dir reset", r, MASK);
    rd(2'd1, r); check("R2 latch reset", r, 16'h0000);
    check("R2 pad_oe reset", pad_oe, 16'h0000);

    // table walk: R1 R5 R6 R9
    for (int k = 0; k < 5; k++) begin
      wr(2'd0, VEC[k][111:96]);
      wr(2'd1, VEC[k][95:80]);
      periph_en = VEC[k][64]; periph_oe = VEC[k][63:48]; periph_do = VEC[k][47:32];
      #1;
      check($sformatf("R1/R5/R6 vec%0d pad_oe", k), pad_oe, VEC[k][31:16]);
      check($sformatf("R1/R5/R6 vec%0d pad_out", k), pad_out, VEC[k][15:0]);
    end
    periph_en = 1'b0; periph_oe = '0; periph_do = '0;

    // R3 latch write/read with dead bit masked (R9)
    wr(2'd1, 16'hFFFF); rd(2'd1, r); check("R3/R9 latch readback", r, 16'hBFFF);
    // R4 write via pin address lands in latch
    wr(2'd2, 16'h7777); rd(2'd1, r); check("R4 pin-addr write", r, 16'h3777);
    // R10 hole address
    wr(2'd3, 16'h0000); rd(2'd1, r); check("R10 latch kept", r, 16'h3777);
    rd(2'd0, r); check("R10 dir kept", r, 16'hFFFF & MASK);
    rd(2'd3, r); check("R10 hole reads zero", r, 16'h0000);
    // R9 dir write to dead bit
    wr(2'd0, 16'h4000); rd(2'd0, r); check("R9 dir dead bit", r, 16'h0000);
    wr(2'd0, 16'hFFFF);

    // R4 synchroniser latency
    @(negedge clk); pad_in = 16'h5A5A;
    @(negedge clk); rd(2'd2, r); check("R4 one edge old", r, 16'h0000);
    @(negedge clk); rd(2'd2, r); check("R4 two edges new", r, 16'h1A5A);

    // R8 loop-through gating
    pad_in = 16'hFFFF; repeat (2) @(negedge clk); #0.5;
    check("R8 input pins pass", periph_di, 16'hBFFF);
    wr(2'd0, 16'h0000); #0.5;
    check("R8 port-driven gated", periph_di, 16'h0000);
    periph_en = 1'b1; periph_oe = 16'h0001; periph_do = 16'h0001; #0.5;
    check("R8 owned pin passes", periph_di, 16'h0001);
    // R7 pin read while owned
    rd(2'd2, r); check("R7 pin read owned", r, 16'hBFFF);
    // R6 enable off ignores oe
    periph_en = 1'b0; #0.5;
    check("R6 en off port drives", pad_out, 16'h3777 & MASK);

    // R2 reset again mid-run
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(2'd1, r); check("R2 latch re-reset", r, 16'h0000);
    check("R2 pad_oe re-reset", pad_oe, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule